// File: doc/BRIEF.md
# Time-slotted serial audio frame receiver

This block is the receive side of a controller that talks to an audio codec over a time-slotted serial link. It watches a frame sync line and a serial data line and samples one bit each time the bit-sample enable pulses. A rising sync marks the start of a frame. The block then collects a 16-bit header, which it calls the tag, and after that twelve 20-bit payload slots. Everything runs in one synchronous clock domain. The falling bit-clock edge arrives as a single-cycle enable.

From the tag, the block reports a codec-ready flag and twelve per-slot valid flags. Each payload slot comes out with its slot number and a one-cycle strobe. The slot is qualified as valid only if the codec was ready and that slot's tag flag was set. A frame that is cut short by an early sync is dropped from that point onward, and the block raises a one-cycle error pulse.

Top module: `slotlink_rx`

## Requirements
- R1: After reset, codecReady, tagValid, tagStrobe, slotStrobe, slotValid and frameErr are all 0.
- R2: Inputs are sampled only in cycles where bitEn is 1. Changes on dataIn or syncIn while bitEn is 0 have no effect, and no output strobe follows such a cycle.
- R3: A sampled 0-to-1 change on syncIn makes that bit the first tag bit of a new frame. In the cycle after the 16th tag bit is sampled, tagStrobe is 1 for one cycle and codecReady equals the first tag bit.
- R4: Tag bits 2 to 13, in arrival order, are the valid flags for slots 1 to 12: tagValid[k-1] is slot k. The last three tag bits are ignored.
- R5: codecReady and tagValid change only together with tagStrobe. They hold their values through frames that end before the tag is complete.
- R6: After each tag, the next 240 bits form slots 1 to 12 of 20 bits each, received MSB first. In the cycle after a slot's 20th bit, slotStrobe pulses with slotNum equal to the slot number, counting 1 to 12 in order, and slotData equal to the slot's bits.
- R7: slotValid at a slotStrobe equals codecReady AND the tag flag of that slot. When codecReady is 0, no slot is reported as valid.
- R8: A sync rise that comes before 256 bits of the current frame have been sampled makes frameErr pulse for exactly one cycle. An unfinished slot gives no strobe, and the new frame starts at that bit.
- R9: Once 256 bits of a frame have been sampled, further bits are ignored until the next sync rise. A sync rise at exactly 256 bits raises no error.
- R10: syncIn held high over several sampled bits counts as a single frame start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| bitEn | input | 1 | One-cycle pulse per serial bit (falling bit-clock edge) |
| syncIn | input | 1 | Frame sync, sampled with bitEn |
| dataIn | input | 1 | Serial data from codec, sampled with bitEn |
| codecReady | output | 1 | Ready flag from the latest tag |
| tagValid | output | 12 | Per-slot valid flags from the latest tag, bit k-1 = slot k |
| tagStrobe | output | 1 | Pulses when a new tag is captured |
| slotData | output | 20 | Latest completed slot payload |
| slotNum | output | 4 | Number (1 to 12) of the latest slot |
| slotValid | output | 1 | Latest slot qualified as valid data |
| slotStrobe | output | 1 | Pulses when a slot completes |
| frameErr | output | 1 | Pulses on a sync rise that cuts a frame short |

## Verification
The hardest case to reach from the ports is a frame cut short by an early sync. The bench has to show at the same time that the unfinished slot is dropped, that the ready and valid flags from the last completed tag survive, and that the error pulse lines up with the start of the next frame. To get there, the stimulus mixes full frames with frames cut at random lengths, including one cut before the tag completes, and frames followed by surplus bits. The spacing between bit enables is random, and dataIn toggles while bitEn is low. The expected slot count, flags and error totals all come from the frame length that the bench chose.

// File: rtl/slotlink_rx_pkg.sv
package slotlink_rx_pkg;
  localparam int SLOT_IDX_W = 4;

  // strobes from control to datapath, one bit time each
  typedef struct packed {
    logic                  shiftEn;
    logic                  capTag;
    logic                  capSlot;
    logic [SLOT_IDX_W-1:0] slotIdx;
    logic                  frameErr;
  } ctlStrobeT;
endpackage

// File: rtl/slotlink_rx_ctl.sv
module slotlink_rx_ctl
  import slotlink_rx_pkg::*;
#(
  parameter int TAG_BITS  = 16,
  parameter int SLOT_BITS = 20,
  parameter int NUM_SLOTS = 12
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      bitEn,
  input  logic      syncIn,
  output ctlStrobeT strb
);
  localparam int FRAME_BITS = TAG_BITS + SLOT_BITS * NUM_SLOTS;
  localparam int CNT_W      = $clog2(FRAME_BITS + 1);
  localparam int SB_W       = $clog2(SLOT_BITS);

  logic             syncPrev;
  logic             inFrame;
  logic [CNT_W-1:0] bitCnt;
  logic [SB_W-1:0]  slotBit;
  logic [SLOT_IDX_W-1:0] slotNo;

  logic             syncRise;
  logic             take;
  logic             inData;
  logic             slotEnd;
  logic [CNT_W-1:0] nextCnt;

  always_comb begin
    syncRise = bitEn && syncIn && !syncPrev;
    take     = syncRise || (bitEn && inFrame && (bitCnt < CNT_W'(FRAME_BITS)));
    nextCnt  = syncRise ? CNT_W'(1) : bitCnt + CNT_W'(1);
    inData   = !syncRise && (bitCnt >= CNT_W'(TAG_BITS));
    slotEnd  = (slotBit == SB_W'(SLOT_BITS - 1));

    strb.shiftEn  = take;
    strb.capTag   = take && (nextCnt == CNT_W'(TAG_BITS));
    strb.capSlot  = take && inData && slotEnd;
    strb.slotIdx  = slotNo;
    strb.frameErr = syncRise && inFrame && (bitCnt != CNT_W'(FRAME_BITS));
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      syncPrev <= 1'b0;
      inFrame  <= 1'b0;
      bitCnt   <= '0;
      slotBit  <= '0;
      slotNo   <= SLOT_IDX_W'(1);
    end else begin
      if (bitEn) syncPrev <= syncIn;
      if (take) begin
        inFrame <= 1'b1;
        bitCnt  <= nextCnt;
        if (syncRise) begin
          slotBit <= '0;
          slotNo  <= SLOT_IDX_W'(1);
        end else if (inData) begin
          if (slotEnd) begin
            slotBit <= '0;
            slotNo  <= slotNo + SLOT_IDX_W'(1);
          end else begin
            slotBit <= slotBit + SB_W'(1);
          end
        end
      end
    end
  end
endmodule

// File: rtl/slotlink_rx_dp.sv
module slotlink_rx_dp
  import slotlink_rx_pkg::*;
#(
  parameter int TAG_BITS  = 16,
  parameter int SLOT_BITS = 20,
  parameter int NUM_SLOTS = 12
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  dataIn,
  input  ctlStrobeT             strb,
  output logic                  codecReady,
  output logic [NUM_SLOTS-1:0]  tagValid,
  output logic                  tagStrobe,
  output logic [SLOT_BITS-1:0]  slotData,
  output logic [SLOT_IDX_W-1:0] slotNum,
  output logic                  slotValid,
  output logic                  slotStrobe,
  output logic                  frameErr
);
  logic [SLOT_BITS-1:0] shReg;
  logic [SLOT_BITS-1:0] nextSh;
  logic [NUM_SLOTS-1:0] tagFlags;

  assign nextSh = {shReg[SLOT_BITS-2:0], dataIn};

  // flag for slot k sits k places after the ready bit
  for (genvar i = 0; i < NUM_SLOTS; i++) begin : g_flag
    assign tagFlags[i] = nextSh[TAG_BITS-2-i];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      shReg      <= '0;
      codecReady <= 1'b0;
      tagValid   <= '0;
      tagStrobe  <= 1'b0;
      slotData   <= '0;
      slotNum    <= '0;
      slotValid  <= 1'b0;
      slotStrobe <= 1'b0;
      frameErr   <= 1'b0;
    end else begin
      tagStrobe  <= strb.capTag;
      slotStrobe <= strb.capSlot;
      frameErr   <= strb.frameErr;
      if (strb.shiftEn) shReg <= nextSh;
      if (strb.capTag) begin
        codecReady <= nextSh[TAG_BITS-1];
        tagValid   <= tagFlags;
      end
      if (strb.capSlot) begin
        slotData  <= nextSh;
        slotNum   <= strb.slotIdx;
        slotValid <= codecReady && tagValid[strb.slotIdx - SLOT_IDX_W'(1)];
      end
    end
  end
endmodule

// File: rtl/slotlink_rx.sv
module slotlink_rx
  import slotlink_rx_pkg::*;
#(
  parameter int TAG_BITS  = 16,
  parameter int SLOT_BITS = 20,
  parameter int NUM_SLOTS = 12
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  bitEn,
  input  logic                  syncIn,
  input  logic                  dataIn,
  output logic                  codecReady,
  output logic [NUM_SLOTS-1:0]  tagValid,
  output logic                  tagStrobe,
  output logic [SLOT_BITS-1:0]  slotData,
  output logic [SLOT_IDX_W-1:0] slotNum,
  output logic                  slotValid,
  output logic                  slotStrobe,
  output logic                  frameErr
);
  ctlStrobeT strb;

  slotlink_rx_ctl #(
    .TAG_BITS(TAG_BITS), .SLOT_BITS(SLOT_BITS), .NUM_SLOTS(NUM_SLOTS)
  ) u_ctl (
    .clk(clk), .rstN(rstN), .bitEn(bitEn), .syncIn(syncIn), .strb(strb)
  );

  slotlink_rx_dp #(
    .TAG_BITS(TAG_BITS), .SLOT_BITS(SLOT_BITS), .NUM_SLOTS(NUM_SLOTS)
  ) u_dp (
    .clk(clk), .rstN(rstN), .dataIn(dataIn), .strb(strb),
    .codecReady(codecReady), .tagValid(tagValid), .tagStrobe(tagStrobe),
    .slotData(slotData), .slotNum(slotNum), .slotValid(slotValid),
    .slotStrobe(slotStrobe), .frameErr(frameErr)
  );
endmodule

// File: rtl/slotlink_rx_chk.sv
module slotlink_rx_chk #(
  parameter int NUM_SLOTS = 12
) (
  input logic                 clk,
  input logic                 rstN,
  input logic                 bitEn,
  input logic                 codecReady,
  input logic [NUM_SLOTS-1:0] tagValid,
  input logic                 tagStrobe,
  input logic [3:0]           slotNum,
  input logic                 slotValid,
  input logic                 slotStrobe,
  input logic                 frameErr
);
  // R2
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    !$past(bitEn) |-> (!tagStrobe && !slotStrobe && !frameErr));

  // R3
  strobe_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(tagStrobe && slotStrobe));

  // R5
  ready_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !tagStrobe |-> ($stable(codecReady) && $stable(tagValid)));

  // R6
  slot_range_chk: assert property (@(posedge clk) disable iff (!rstN)
    slotStrobe |-> (slotNum >= 4'd1 && slotNum <= 4'(NUM_SLOTS)));

  // R7
  valid_ready_chk: assert property (@(posedge clk) disable iff (!rstN)
    (slotStrobe && slotValid) |-> codecReady);

  // R8
  err_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    frameErr |=> !frameErr);
endmodule

bind slotlink_rx slotlink_rx_chk #(.NUM_SLOTS(NUM_SLOTS)) u_chk (
  .clk(clk), .rstN(rstN), .bitEn(bitEn), .codecReady(codecReady),
  .tagValid(tagValid), .tagStrobe(tagStrobe), .slotNum(slotNum),
  .slotValid(slotValid), .slotStrobe(slotStrobe), .frameErr(frameErr)
);

// File: tb/slotlink_rx_tb.sv
`timescale 1ns/1ps
module slotlink_rx_tb;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic bitEn = 1'b0;
  logic syncIn = 1'b0;
  logic dataIn = 1'b0;
  logic        codecReady;
  logic [11:0] tagValid;
  logic        tagStrobe;
  logic [19:0] slotData;
  logic [3:0]  slotNum;
  logic        slotValid;
  logic        slotStrobe;
  logic        frameErr;

  always #2 clk = ~clk;

  slotlink_rx u_dut (
    .clk(clk), .rstN(rstN), .bitEn(bitEn), .syncIn(syncIn), .dataIn(dataIn),
    .codecReady(codecReady), .tagValid(tagValid), .tagStrobe(tagStrobe),
    .slotData(slotData), .slotNum(slotNum), .slotValid(slotValid),
    .slotStrobe(slotStrobe), .frameErr(frameErr)
  );

  int nChk = 0;
  int nFail = 0;
  int slotSeen = 0;
  int tagSeen = 0;
  int errSeen = 0;
  int errExp = 0;
  bit prevShort = 1'b0;
  bit finished = 1'b0;
  logic        mReady;
  logic [11:0] mVld;
  logic [19:0] mPay [1:12];
  logic        refReady = 1'b0;
  logic [11:0] refVld = '0;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChk++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // sample after each rising edge, away from the negedge driver
  always @(posedge clk) begin
    #1;
    if (rstN && !finished) begin
      if (tagStrobe) begin
        tagSeen++;
        chk("R3 codecReady at tag", 32'(codecReady), 32'(mReady));
        chk("R4 tagValid at tag", 32'(tagValid), 32'(mVld));
      end
      if (slotStrobe) begin
        slotSeen++;
        chk("R6 slotNum order", 32'(slotNum), 32'(slotSeen));
        if (slotSeen >= 1 && slotSeen <= 12) begin
          chk("R6 slotData MSB first", 32'(slotData), 32'(mPay[slotSeen]));
          chk("R7 slotValid", 32'(slotValid), 32'(mReady && mVld[slotSeen-1]));
        end
      end
      if (frameErr) errSeen++;
    end
  end

  task automatic sendBit(input logic s, input logic d);
    @(negedge clk);
    syncIn = s; dataIn = d; bitEn = 1'b1;
    @(negedge clk);
    bitEn = 1'b0; dataIn = 1'($urandom);
    repeat ($urandom % 3) begin
      @(negedge clk);
      dataIn = 1'($urandom);
    end
  endtask

  function automatic int expSlotCount(input int nbits);
    int c;
    if (nbits < 16) return 0;
    c = (nbits - 16) / 20;
    return (c > 12) ? 12 : c;
  endfunction

  task automatic runFrame(input logic ready, input logic [11:0] vld,
                          input int nbits, input int extra);
    logic fb [0:255];
    int sl;
    fb[0] = ready;
    for (int i = 0; i < 12; i++) fb[1+i] = vld[i];
    for (int i = 13; i < 16; i++) fb[i] = 1'($urandom);
    for (int k = 1; k <= 12; k++) begin
      mPay[k] = 20'($urandom);
      for (int j = 0; j < 20; j++) fb[16 + 20*(k-1) + j] = mPay[k][19-j];
    end
    mReady = ready; mVld = vld;
    slotSeen = 0; tagSeen = 0;
    if (prevShort) errExp++;
    prevShort = (nbits < 256);
    if (nbits >= 16) begin refReady = ready; refVld = vld; end
    sl = 1 + int'($urandom % 6);
    if (sl >= nbits) sl = nbits - 1;
    for (int i = 0; i < nbits; i++) sendBit(i < sl, fb[i]);
    for (int i = 0; i < extra; i++) sendBit(1'b0, 1'($urandom));
    repeat (3) @(negedge clk);
    chk("R6 slot count", 32'(slotSeen), 32'(expSlotCount(nbits)));
    chk("R10 tag count", 32'(tagSeen), 32'(nbits >= 16));
    chk("R5 codecReady held", 32'(codecReady), 32'(refReady));
    chk("R5 tagValid held", 32'(tagValid), 32'(refVld));
    chk("R8 frameErr total", 32'(errSeen), 32'(errExp));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      nFail++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", nChk, nFail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20417));
    repeat (3) @(negedge clk);
    chk("R1 codecReady reset", 32'(codecReady), 32'd0);
    chk("R1 tagValid reset", 32'(tagValid), 32'd0);
    chk("R1 strobes reset", 32'({tagStrobe, slotStrobe, slotValid, frameErr}), 32'd0);
    rstN = 1'b1;
    // directed corners
    runFrame(1'b1, 12'h01F, 256, 0);          // R4 unsupported upper slots clear
    runFrame(1'b0, 12'hFFF, 256, 0);          // R7 not ready gates all
    runFrame(1'b1, 12'hA5C, 256, 0);
    runFrame(1'b0, 12'h3C3, 10, 0);           // R8 cut before tag, R5 hold
    runFrame(1'b1, 12'hFFF, 100, 0);          // R8 partial slot dropped
    runFrame(1'b1, 12'h81F, 256, 9);          // R9 surplus bits ignored
    runFrame(1'b1, 12'h00F, 256, 0);          // R9 no error at exactly 256
    // constrained random frames
    for (int f = 0; f < 30; f++) begin
      logic r;
      int nb;
      int ex;
      r  = ($urandom % 4) != 0;
      nb = (($urandom % 5) == 0) ? 20 + int'($urandom % 230) : 256;
      ex = (nb == 256 && ($urandom % 4) == 0) ? int'($urandom % 12) : 0;
      runFrame(r, 12'($urandom), nb, ex);
    end
    runFrame(1'b1, 12'h555, 256, 0);
    chk("R2 no strobe while idle", 32'({tagStrobe, slotStrobe, frameErr}), 32'd0);
    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nChk, nFail);
    $finish;
  end
endmodule